// File: doc/BRIEF.md
# Serial Divider Programming Port

This block is the three-wire programming front end of a frequency synthesizer. A host sends a word one bit at a time on a data line, with one bit taken on each rising edge of a serial clock line. All three serial lines are synchronized into the system clock domain. Each bit enters a single shift register, and the most recent bit always sits at position 0.

The final bit of every word is a steering bit, not payload. A rising edge on the load-enable line copies the payload into one of two holding registers, and the steering bit picks which one. A steering value of 1 selects the narrow reference-divider register, for 15 payload bits and a 16-bit word. A steering value of 0 selects the wide main-divider register, for 18 payload bits and a 19-bit word. The block raises a one-cycle update strobe beside each register when that register is written.

The load-enable line idles high, as if pulled up when undriven. A high level that is already present when reset ends does not count as a load.

Top module: `serprog_port`

## Requirements
- R1: A synchronous active-high reset clears both holding registers and the shift register to zero and holds both update strobes low.
- R2: Each rising edge of the serial clock shifts the data-line level into position 0 of the shift register, and older bits move one place up. Bits are sent payload MSB first, then the steering bit.
- R3: On a load-enable rising edge with steering bit 1, the reference register (15 bits) takes shift positions [15:1], and `ref_upd` is high for exactly one system cycle.
- R4: On a load-enable rising edge with steering bit 0, the main register (18 bits) takes shift positions [18:1], and `main_upd` is high for exactly one system cycle.
- R5: Each rising edge of load enable causes exactly one transfer. Holding load enable high causes no further transfer, even when more bits are shifted in while it is high.
- R6: A transfer leaves the register that was not selected unchanged, and its strobe stays low.
- R7: Shifting with no load-enable rising edge changes neither holding register.
- R8: Bits sent before the last 16 (reference) or last 19 (main) bits of a word have no effect on the loaded value.
- R9: The synchronized load enable resets to high, so a line held high through reset and after it produces no transfer.
- R10: The two update strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous to clk |
| ser_data | input | 1 | Serial data, sampled on ser_clk rising edge |
| ser_le | input | 1 | Load enable; transfer on rising edge, idles high |
| ref_word | output | 15 | Reference divider setting |
| main_word | output | 18 | Main divider setting |
| ref_upd | output | 1 | One-cycle strobe when ref_word is written |
| main_upd | output | 1 | One-cycle strobe when main_word is written |

## Verification
The assertions check four things on every cycle. The two strobes are exclusive. Each strobe lasts a single cycle. A holding register changes only in a cycle where its strobe is high. Each write carries the shift positions that were present at the load edge.

Some behaviour only the bench scenarios can show, because it depends on a whole serial sequence. These are the bit ordering, the dropping of extra leading bits, the absence of any transfer while load enable stays high or was high through reset, and the payload values that arrive at the outputs.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

   typedef enum logic {
      TGT_MAIN = 1'b0,
      TGT_REF  = 1'b1
   } tgt_e;

   function automatic int wmax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("sp_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] st;
         for (genvar i = 0; i < STAGES; i++) begin : g_st
            if (i == 0) begin : g_first
               always_ff @(posedge clk) begin
                  if (rst) st[0] <= RST_VAL;
                  else     st[0] <= d;
               end
            end else begin : g_next
               always_ff @(posedge clk) begin
                  if (rst) st[i] <= RST_VAL;
                  else     st[i] <= st[i-1];
               end
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sp_rise.sv
module sp_rise #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic rise
);
   logic prev;

   always_ff @(posedge clk) begin
      if (rst) prev <= RST_VAL;
      else     prev <= d;
   end

   assign rise = d & ~prev;
endmodule

// File: rtl/sp_shift.sv
module sp_shift #(
   parameter int W = 19
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] q
);
   generate
      if (W < 2) begin : g_bad
         $error("sp_shift: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (en) q <= {q[W-2:0], din};
   end
endmodule

// File: rtl/sp_hold.sv
module sp_hold #(
   parameter int W = 15
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         upd
);
   generate
      if (W < 1) begin : g_bad
         $error("sp_hold: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         q   <= '0;
         upd <= 1'b0;
      end else begin
         upd <= load;
         if (load) q <= d;
      end
   end
endmodule

// File: rtl/serprog_port.sv
module serprog_port
   import serprog_pkg::*;
#(
   parameter int REF_W       = 15,
   parameter int MAIN_W      = 18,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_le,
   output logic [REF_W-1:0]  ref_word,
   output logic [MAIN_W-1:0] main_word,
   output logic              ref_upd,
   output logic              main_upd
);
   localparam int SHIFT_W = wmax(REF_W, MAIN_W) + 1;

   generate
      if (REF_W < 1 || MAIN_W < 1) begin : g_bad_w
         $error("serprog_port: payload widths must be positive");
      end
      if (REF_W == MAIN_W) begin : g_bad_eq
         $error("serprog_port: payload widths must differ");
      end
   endgenerate

   logic sclk_s, sdat_s, le_s;
   logic sclk_rise, le_rise;
   logic [SHIFT_W-1:0] shift_q;
   tgt_e tgt;
   logic ld_ref, ld_main;

   sp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
      .clk(clk), .rst(rst), .d(ser_clk), .q(sclk_s));
   sp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
      .clk(clk), .rst(rst), .d(ser_data), .q(sdat_s));
   // load enable idles high, so its synchronizer resets high
   sp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_le (
      .clk(clk), .rst(rst), .d(ser_le), .q(le_s));

   sp_rise #(.RST_VAL(1'b0)) u_rise_clk (
      .clk(clk), .rst(rst), .d(sclk_s), .rise(sclk_rise));
   sp_rise #(.RST_VAL(1'b1)) u_rise_le (
      .clk(clk), .rst(rst), .d(le_s), .rise(le_rise));

   sp_shift #(.W(SHIFT_W)) u_shift (
      .clk(clk), .rst(rst), .en(sclk_rise), .din(sdat_s), .q(shift_q));

   assign tgt     = tgt_e'(shift_q[0]);
   assign ld_ref  = le_rise && (tgt == TGT_REF);
   assign ld_main = le_rise && (tgt == TGT_MAIN);

   sp_hold #(.W(REF_W)) u_ref (
      .clk(clk), .rst(rst), .load(ld_ref),
      .d(shift_q[REF_W:1]), .q(ref_word), .upd(ref_upd));
   sp_hold #(.W(MAIN_W)) u_main (
      .clk(clk), .rst(rst), .load(ld_main),
      .d(shift_q[MAIN_W:1]), .q(main_word), .upd(main_upd));

   // R10
   strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ref_upd, main_upd}));
   // R3
   ref_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      ref_upd |=> !ref_upd);
   // R4
   main_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      main_upd |=> !main_upd);
   // R6
   ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(ref_word) |-> ref_upd);
   // R7
   main_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(main_word) |-> main_upd);
   // R3
   ref_data_chk: assert property (@(posedge clk) disable iff (rst)
      ref_upd |-> (ref_word == $past(shift_q[REF_W:1])) && $past(shift_q[0]));
   // R4
   main_data_chk: assert property (@(posedge clk) disable iff (rst)
      main_upd |-> (main_word == $past(shift_q[MAIN_W:1])) && !$past(shift_q[0]));
endmodule

// File: tb/sim_serprog_port.sv
module sim_serprog_port;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b1;
   logic [14:0] ref_word;
   logic [17:0] main_word;
   logic ref_upd, main_upd;

   int checks = 0, fails = 0;
   int ref_cnt = 0, main_cnt = 0;
   logic [18:0] mdl_sh;
   logic [14:0] exp_ref;
   logic [17:0] exp_main;

   always #4 clk = ~clk;

   serprog_port u0 (
      .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_le(ser_le), .ref_word(ref_word), .main_word(main_word),
      .ref_upd(ref_upd), .main_upd(main_upd));

   always @(negedge clk) begin
      if (!rst) begin
         if (ref_upd)  ref_cnt++;
         if (main_upd) main_cnt++;
      end
   end

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      ser_data = b;
      wclk(3);
      ser_clk = 1'b1;
      mdl_sh = {mdl_sh[17:0], b};
      wclk(3);
      ser_clk = 1'b0;
      wclk(1);
   endtask

   task automatic send_word(input logic [31:0] w, input int len);
      for (int i = len - 1; i >= 0; i--) send_bit(w[i]);
   endtask

   function automatic logic [14:0] pick_ref(input logic [18:0] s);
      return s[15:1];
   endfunction

   function automatic logic [17:0] pick_main(input logic [18:0] s);
      return s[18:1];
   endfunction

   // load pulse and model update; checks both registers and strobe counts
   task automatic pulse_and_check(input string req);
      int r0, m0;
      logic tgt_ref;
      r0 = ref_cnt; m0 = main_cnt;
      tgt_ref = mdl_sh[0];
      ser_le = 1'b1;
      wclk(5);
      ser_le = 1'b0;
      wclk(6);
      if (tgt_ref) exp_ref = pick_ref(mdl_sh);
      else         exp_main = pick_main(mdl_sh);
      chk({req, " ref_word"}, 32'(ref_word), 32'(exp_ref));
      chk({req, " main_word"}, 32'(main_word), 32'(exp_main));
      chk({req, " ref strobes"}, 32'(ref_cnt - r0), tgt_ref ? 32'd1 : 32'd0);
      chk({req, " main strobes"}, 32'(main_cnt - m0), tgt_ref ? 32'd0 : 32'd1);
   endtask

   initial begin
      int r0, m0;
      void'($urandom(32'd1504));
      mdl_sh = '0; exp_ref = '0; exp_main = '0;
      wclk(5);
      rst = 1'b0;
      wclk(2);
      // R1 reset state
      chk("R1 ref_word", 32'(ref_word), 0);
      chk("R1 main_word", 32'(main_word), 0);
      chk("R1 strobes", {30'd0, ref_upd, main_upd}, 0);
      // R9 load enable high through and after reset: no transfer
      wclk(10);
      chk("R9 no strobe with le idle high", 32'(ref_cnt + main_cnt), 0);
      ser_le = 1'b0;
      wclk(6);
      chk("R9 no strobe on le fall", 32'(ref_cnt + main_cnt), 0);

      // R3 directed reference load, steering bit 1
      send_word({15'h5A3C, 1'b1}, 16);
      pulse_and_check("R3 R2 ref load");
      // R4 directed main load, steering bit 0
      send_word({18'h2_C3A5, 1'b0}, 19);
      pulse_and_check("R4 R6 main load");
      // R8 extra leading bits dropped for a reference word
      send_word({4'hF, 15'h0001, 1'b1}, 20);
      pulse_and_check("R8 ref extra bits");
      // R7 shifting without load leaves both registers
      send_word({18'h1_FFFF, 1'b0}, 19);
      wclk(6);
      chk("R7 ref unchanged", 32'(ref_word), 32'(exp_ref));
      chk("R7 main unchanged", 32'(main_word), 32'(exp_main));

      // R5 held high: one transfer, none for bits shifted while high
      send_word({18'h0_0F0F, 1'b0}, 19);
      r0 = ref_cnt; m0 = main_cnt;
      ser_le = 1'b1;
      wclk(6);
      exp_main = pick_main(mdl_sh);
      send_word({15'h7777, 1'b1}, 16);
      wclk(4);
      chk("R5 one main transfer", 32'(main_cnt - m0), 1);
      chk("R5 no ref transfer while high", 32'(ref_cnt - r0), 0);
      chk("R5 ref unchanged", 32'(ref_word), 32'(exp_ref));
      chk("R5 main value", 32'(main_word), 32'(exp_main));
      ser_le = 1'b0;
      wclk(6);
      pulse_and_check("R5 later pulse ref");

      // random mix
      for (int it = 0; it < 40; it++) begin
         logic [31:0] pay;
         int extra, len;
         logic tref;
         tref = 1'($urandom);
         pay = $urandom;
         extra = $urandom_range(0, 3);
         len = (tref ? 16 : 19) + extra;
         pay = {pay[30:0], tref};
         send_word(pay, len);
         if ($urandom_range(0, 4) == 0) begin
            wclk(6);
            chk("R7 random no load ref", 32'(ref_word), 32'(exp_ref));
            chk("R7 random no load main", 32'(main_word), 32'(exp_main));
         end else begin
            pulse_and_check(tref ? "R3 R8 random ref" : "R4 R8 random main");
         end
      end

      // R1 reset mid-run clears
      rst = 1'b1;
      wclk(3);
      rst = 1'b0;
      wclk(2);
      chk("R1 ref after reset", 32'(ref_word), 0);
      chk("R1 main after reset", 32'(main_word), 0);
      mdl_sh = '0; exp_ref = '0; exp_main = '0;
      send_word({15'h0000, 1'b1}, 16);
      pulse_and_check("R2 shift cleared by reset");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule